// File: doc/BRIEF.md
# Interrupt Aggregator with NMI Routing

This block sits between a set of peripheral interrupt lines and a processor interrupt controller. Peripheral lines are grouped into per-IRQ slots of up to `GRP_W` members each. Every member line passes through a two-stage synchronizer into the system clock domain. The members of a slot are ORed together to form that IRQ's hardware request. A member-count function in the package fixes the membership of each slot. Most slots have one member. A few merge two, five or six. Slots 17, 20, 26 and 27 have none.

Each IRQ output carries its hardware request combined with a software-settable pending bit. In the default mode the request reaches the output exactly 13 clocks after the source line first goes active, counting the synchronizer. In the quick mode the request is delivered as soon as it leaves the synchronizer. A selector routes any one IRQ output to a non-maskable interrupt line. That line is gated by an arm bit that only changes while an unlock input is held.

Software reaches the block through a simple synchronous bus. Writes take effect on the clock edge. Read data is combinational from the address. The bus holds a per-IRQ identity word at byte offset 4×n, the NMI control word at 0x80, the pending word at 0x84 and the latency-mode word at 0x88.

Top module: `irq_aggregator`

## Requirements
- R1: The identity word at byte offset 4×n returns, in bit m, the synchronized level of member m of slot n. A member bit follows its input after two clock edges. Bits at and above the slot's member count read 0.
- R2: IRQ output n is the OR of all the members of slot n, ORed with software pending bit n.
- R3: With the latency-mode bit clear (bit 0 of 0x88, its reset value), an IRQ output rises on the 13th clock edge after its source line rises. It falls on the 13th edge after the line falls, and not earlier.
- R4: With the latency-mode bit set, an IRQ output follows its source line on the 2nd clock edge and is still low after the 1st edge.
- R5: Reading 0x84 returns the IRQ outputs, with bit n for IRQ n. Writing 1 to bit n when it reads 0 sets software pending n. Writing 1 when it reads 1 clears software pending n, so a bit held only by hardware stays hardware-only. Writing 0 leaves the bit unchanged.
- R6: The NMI output equals IRQ output s, where s is the select field in bits 4:0 of 0x80, while the arm bit (bit 8 of 0x80) is 1. While the arm bit is 0 the NMI output is low.
- R7: A write to 0x80 updates the arm bit only while the unlock input is high. Otherwise the arm bit keeps its value, and the select field is still written.
- R8: Slots 17, 20, 26 and 27 read 0 in their identity words and in the pending word. Their IRQ outputs stay low, even after a software set.
- R9: After reset all registers and outputs are zero. Reads of offsets other than 0x00–0x88 (word-aligned) return 0. Writes to them change no register.
- R10: 0x80 reads back the select field in bits 4:0 and the arm bit in bit 8. 0x88 reads back the latency-mode bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_IRQ*GRP_W | Peripheral lines, member m of slot n at bit n*GRP_W+m |
| unlock | input | 1 | Allows the NMI arm bit to be written |
| busAddr | input | ADDR_W | Byte address |
| busWr | input | 1 | Write strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr |
| irqOut | output | NUM_IRQ | IRQ lines to the interrupt controller |
| nmiOut | output | 1 | Non-maskable interrupt line |

## Verification
A stuck or misrouted synchronizer flop shows up at the identity word two edges after a line toggles. The bench reaches every member position of every slot this way. A delay line that is too short or too long moves the IRQ edge away from edge 13, and the bench checks edges 12 and 13 on both the rise and the fall. A wrong pending or arm state appears on the very next read or on nmiOut one edge after the write. For that reason each write is followed at once by a read back and a look at the outputs.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef struct packed {
    logic pendWr;
    logic quickPath;
  } ctrlStrobe_t;

  function automatic int unsigned memberCount(int unsigned slot);
    case (slot)
      1, 6:               return 2;
      4:                  return 5;
      5:                  return 6;
      17, 20, 26, 27:     return 0;
      default:            return 1;
    endcase
  endfunction

endpackage

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int GRP_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LAT_CYCLES  = 13
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IRQ*GRP_W-1:0] srcIn,
  input  ctrlStrobe_t              strobe,
  input  logic [NUM_IRQ-1:0]       pendData,
  output logic [NUM_IRQ*GRP_W-1:0] identFlat,
  output logic [NUM_IRQ-1:0]       irqOut
);

  localparam int DELAY_STAGES = LAT_CYCLES - SYNC_STAGES;

  logic [NUM_IRQ-1:0] hwLevel;
  logic [NUM_IRQ-1:0] usedMask;
  logic [NUM_IRQ-1:0] swPend;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_slot
    localparam int CNT = (memberCount(g) > GRP_W) ? GRP_W : memberCount(g);
    localparam logic [GRP_W-1:0] MEMBER_MASK = GRP_W'((64'd1 << CNT) - 64'd1);

    logic [SYNC_STAGES-1:0][GRP_W-1:0] syncQ;
    logic [DELAY_STAGES-1:0]           dlyQ;
    logic [GRP_W-1:0]                  memberLvl;
    logic                              orSync;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
      end else begin
        syncQ[0] <= srcIn[g*GRP_W +: GRP_W];
        for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      end
    end

    assign memberLvl = syncQ[SYNC_STAGES-1] & MEMBER_MASK;
    assign orSync    = |memberLvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dlyQ <= '0;
      end else begin
        dlyQ[0] <= orSync;
        for (int k = 1; k < DELAY_STAGES; k++) dlyQ[k] <= dlyQ[k-1];
      end
    end

    assign identFlat[g*GRP_W +: GRP_W] = memberLvl;
    assign hwLevel[g]  = strobe.quickPath ? orSync : dlyQ[DELAY_STAGES-1];
    assign usedMask[g] = (CNT != 0);
  end

  assign irqOut = (hwLevel | swPend) & usedMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swPend <= '0;
    end else if (strobe.pendWr) begin
      for (int n = 0; n < NUM_IRQ; n++) begin
        if (pendData[n]) swPend[n] <= ~irqOut[n] & usedMask[n];
      end
    end
  end

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int GRP_W   = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     unlock,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWr,
  input  logic [DATA_W-1:0]        busWdata,
  input  logic [NUM_IRQ*GRP_W-1:0] identFlat,
  input  logic [NUM_IRQ-1:0]       irqOut,
  output logic [DATA_W-1:0]        busRdata,
  output ctrlStrobe_t              strobe,
  output logic [NUM_IRQ-1:0]       pendData,
  output logic [$clog2(NUM_IRQ)-1:0] nmiSrcSel,
  output logic                     nmiArm
);

  localparam int SEL_W   = $clog2(NUM_IRQ);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int ARM_BIT = 8;
  localparam logic [IDX_W-1:0] NMI_IDX  = IDX_W'(NUM_IRQ);
  localparam logic [IDX_W-1:0] PEND_IDX = IDX_W'(NUM_IRQ + 1);
  localparam logic [IDX_W-1:0] LAT_IDX  = IDX_W'(NUM_IRQ + 2);

  logic             aligned;
  logic [IDX_W-1:0] wordIdx;
  logic             identHit, nmiHit, pendHit, latHit;
  logic             quickPath;
  logic [SEL_W-1:0] slotIdx;

  assign aligned  = (busAddr[1:0] == 2'b00);
  assign wordIdx  = busAddr[ADDR_W-1:2];
  assign identHit = aligned && (wordIdx < NMI_IDX);
  assign nmiHit   = aligned && (wordIdx == NMI_IDX);
  assign pendHit  = aligned && (wordIdx == PEND_IDX);
  assign latHit   = aligned && (wordIdx == LAT_IDX);
  assign slotIdx  = wordIdx[SEL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiSrcSel <= '0;
      nmiArm    <= 1'b0;
      quickPath <= 1'b0;
    end else if (busWr) begin
      if (nmiHit) begin
        nmiSrcSel <= busWdata[SEL_W-1:0];
        if (unlock) nmiArm <= busWdata[ARM_BIT];
      end
      if (latHit) quickPath <= busWdata[0];
    end
  end

  assign strobe.pendWr    = busWr && pendHit;
  assign strobe.quickPath = quickPath;
  assign pendData         = busWdata[NUM_IRQ-1:0];

  always_comb begin
    busRdata = '0;
    if (identHit) begin
      busRdata = DATA_W'(identFlat[slotIdx*GRP_W +: GRP_W]);
    end else if (nmiHit) begin
      busRdata[SEL_W-1:0] = nmiSrcSel;
      busRdata[ARM_BIT]   = nmiArm;
    end else if (pendHit) begin
      busRdata = DATA_W'(irqOut);
    end else if (latHit) begin
      busRdata[0] = quickPath;
    end
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int GRP_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LAT_CYCLES  = 13,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IRQ*GRP_W-1:0] srcIn,
  input  logic                     unlock,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWr,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  output logic [NUM_IRQ-1:0]       irqOut,
  output logic                     nmiOut
);

  localparam int SEL_W = $clog2(NUM_IRQ);

  ctrlStrobe_t                strobe;
  logic [NUM_IRQ-1:0]         pendData;
  logic [NUM_IRQ*GRP_W-1:0]   identFlat;
  logic [SEL_W-1:0]           nmiSrcSel;
  logic                       nmiArm;

  irq_agg_ctrl #(
    .NUM_IRQ(NUM_IRQ), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .unlock(unlock),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .identFlat(identFlat), .irqOut(irqOut),
    .busRdata(busRdata), .strobe(strobe), .pendData(pendData),
    .nmiSrcSel(nmiSrcSel), .nmiArm(nmiArm)
  );

  irq_agg_datapath #(
    .NUM_IRQ(NUM_IRQ), .GRP_W(GRP_W),
    .SYNC_STAGES(SYNC_STAGES), .LAT_CYCLES(LAT_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn),
    .strobe(strobe), .pendData(pendData),
    .identFlat(identFlat), .irqOut(irqOut)
  );

  assign nmiOut = nmiArm & irqOut[nmiSrcSel];

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_IRQ = 32,
  parameter int ADDR_W  = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       unlock,
  input logic                       busWr,
  input logic [ADDR_W-1:0]          busAddr,
  input logic                       nmiArm,
  input logic [$clog2(NUM_IRQ)-1:0] nmiSrcSel,
  input logic                       quickPath,
  input logic                       nmiOut,
  input logic [NUM_IRQ-1:0]         irqOut
);

  localparam logic [ADDR_W-1:0] NMI_ADDR = ADDR_W'(NUM_IRQ * 4);
  localparam logic [ADDR_W-1:0] LAT_ADDR = ADDR_W'(NUM_IRQ * 4 + 8);

  // R7: without unlock the arm bit cannot move
  p_arm_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    !unlock |=> $stable(nmiArm));

  // R6: disarmed NMI stays low
  p_nmi_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !nmiArm |-> !nmiOut);

  // R10: select field only changes through a write to its word
  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == NMI_ADDR) |=> $stable(nmiSrcSel));

  // R10: latency-mode bit only changes through a write to its word
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == LAT_ADDR) |=> $stable(quickPath));

  if (NUM_IRQ > 27) begin : g_unused
    // R8: empty slots never raise their line
    p_empty_low_r8: assert property (@(posedge clk) disable iff (!rstN)
      !irqOut[17] && !irqOut[20] && !irqOut[26] && !irqOut[27]);
  end

endmodule

bind irq_aggregator irq_agg_checker #(
  .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .unlock(unlock), .busWr(busWr), .busAddr(busAddr),
  .nmiArm(nmiArm), .nmiSrcSel(nmiSrcSel), .quickPath(strobe.quickPath),
  .nmiOut(nmiOut), .irqOut(irqOut)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

  localparam int NIRQ = 32;
  localparam int GW   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NIRQ*GW-1:0] srcIn = '0;
  logic              unlock = 1'b0;
  logic [7:0]        busAddr = '0;
  logic              busWr = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [NIRQ-1:0]   irqOut;
  logic              nmiOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .unlock(unlock),
    .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut), .nmiOut(nmiOut)
  );

  function automatic int members(int s);
    if (s == 1 || s == 6) return 2;
    if (s == 4) return 5;
    if (s == 5) return 6;
    if (s == 17 || s == 20 || s == 26 || s == 27) return 0;
    return 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic unl);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1; unlock = unl;
    @(negedge clk);
    busWr = 1'b0; unlock = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 irqOut", irqOut, 0);
    chk("R9 nmiOut", 32'(nmiOut), 0);
    rd(8'h80, d); chk("R9 nmi word", d, 0);
    rd(8'h84, d); chk("R9 pend word", d, 0);
    rd(8'h88, d); chk("R9 mode word", d, 0);

    // R10 mode readback, then quick-mode sweep of every member
    wr(8'h88, 32'h1, 1'b0);
    rd(8'h88, d); chk("R10 mode word", d, 1);
    for (int n = 0; n < NIRQ; n++) begin
      for (int m = 0; m < GW; m++) begin
        logic hit;
        hit = (m < members(n));
        @(negedge clk); srcIn = '0; srcIn[n*GW+m] = 1'b1;
        @(negedge clk);
        chk("R4 early", irqOut, 0);
        @(negedge clk);
        chk("R2 R8 irq", irqOut, hit ? (32'd1 << n) : 32'd0);
        rd(8'(4*n), d); chk("R1 ident", d, hit ? (32'd1 << m) : 32'd0);
        rd(8'h84, d);   chk("R5 pend read", d, irqOut);
        srcIn = '0;
        repeat (3) @(negedge clk);
      end
    end

    // R1 R2 full group with extra bits outside membership
    @(negedge clk); srcIn[5*GW +: GW] = 8'hFF;
    repeat (2) @(negedge clk);
    rd(8'h14, d); chk("R1 group ident", d, 32'h3F);
    chk("R2 group or", irqOut, 32'd1 << 5);
    srcIn = '0; repeat (3) @(negedge clk);

    // R3 fixed latency on rise and fall
    wr(8'h88, 32'h0, 1'b0);
    @(negedge clk); srcIn[8*GW] = 1'b1;
    repeat (12) @(negedge clk);
    chk("R3 edge12 low", irqOut, 0);
    @(negedge clk);
    chk("R3 edge13 high", irqOut, 32'd1 << 8);
    srcIn = '0;
    repeat (12) @(negedge clk);
    chk("R3 fall edge12", irqOut, 32'd1 << 8);
    @(negedge clk);
    chk("R3 fall edge13", irqOut, 0);

    // R5 software pending toggle and no-effect zero write
    wr(8'h84, 32'd1 << 9, 1'b0);
    rd(8'h84, d); chk("R5 set", d, 32'd1 << 9);
    chk("R5 set irq", irqOut, 32'd1 << 9);
    wr(8'h84, 32'd1 << 9, 1'b0);
    rd(8'h84, d); chk("R5 clear", d, 0);
    wr(8'h84, 32'd1 << 10, 1'b0);
    wr(8'h84, 32'h0, 1'b0);
    rd(8'h84, d); chk("R5 zero write", d, 32'd1 << 10);
    wr(8'h84, 32'd1 << 10, 1'b0);

    // R5 write-1 while held by hardware only clears nothing sticky
    wr(8'h88, 32'h1, 1'b0);
    @(negedge clk); srcIn[12*GW] = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h84, 32'd1 << 12, 1'b0);
    rd(8'h84, d); chk("R5 hw held", d, 32'd1 << 12);
    srcIn = '0; repeat (3) @(negedge clk);
    chk("R5 hw release", irqOut, 0);

    // R8 software set on an empty slot
    wr(8'h84, 32'd1 << 17, 1'b0);
    rd(8'h84, d); chk("R8 empty pend", d, 0);
    chk("R8 empty irq", irqOut, 0);

    // R7 R6 arm protection
    wr(8'h80, 32'h109, 1'b0);
    rd(8'h80, d); chk("R7 locked arm", d, 32'h009);
    wr(8'h84, 32'd1 << 9, 1'b0);
    chk("R6 disarmed", 32'(nmiOut), 0);
    wr(8'h80, 32'h109, 1'b1);
    rd(8'h80, d); chk("R10 nmi word", d, 32'h109);
    chk("R6 armed", 32'(nmiOut), 1);
    wr(8'h80, 32'h009, 1'b0);
    rd(8'h80, d); chk("R7 keep arm", d, 32'h109);
    wr(8'h84, 32'd1 << 9, 1'b0);
    chk("R6 follows irq", 32'(nmiOut), 0);

    // R6 select sweep
    for (int s = 0; s < NIRQ; s++) begin
      wr(8'h80, 32'h100 | 32'(s), 1'b1);
      wr(8'h84, 32'd1 << s, 1'b0);
      chk("R6 sel route", 32'(nmiOut), (members(s) != 0) ? 32'd1 : 32'd0);
      wr(8'h84, 32'd1 << s, 1'b0);
      if (members(s) != 0) chk("R6 sel clear", 32'(nmiOut), 0);
    end
    wr(8'h80, 32'h0, 1'b1);
    wr(8'h84, 32'd1, 1'b0);
    chk("R6 disarm", 32'(nmiOut), 0);
    wr(8'h84, 32'd1, 1'b0);

    // R9 unmapped and misaligned accesses
    wr(8'h8C, 32'hFFFF_FFFF, 1'b1);
    rd(8'h8C, d); chk("R9 unmapped read", d, 0);
    rd(8'h88, d); chk("R9 mode intact", d, 1);
    rd(8'h80, d); chk("R9 nmi intact", d, 0);
    wr(8'h85, 32'hFFFF_FFFF, 1'b0);
    rd(8'h84, d); chk("R9 misaligned", d, 0);
    rd(8'hFC, d); chk("R9 high read", d, 0);

    summary();
  end

endmodule